// File: doc/BRIEF.md
# Tri-Level Pulse Trim Counter

This block holds an 8-bit trim code and moves it one step at a time in response to pulses on a single three-level control line. An analog front end, outside this block, resolves the line into a 2-bit level code: rest (mid), low, high, or a program level. A pulse is a trip away from rest and back. A trip down to the low level raises the code by one. A trip up to the high level lowers the code by one. In both cases the step is applied when the line comes back to rest. The code clamps at both ends and never wraps.

Short trips are treated as noise and rejected. The minimum width is set in microseconds and converted to clock cycles from the clock frequency parameter. Steps are applied only while the counter-enable input is high. After enable rises, and after a store sequencer reports that a save has finished, the first valid pulse is swallowed, because the level of the line at that moment is not known. The same store sequencer can overwrite the code through a parallel load strobe. The load wins over any step that falls in the same cycle.

Top module: `tlc_trim_counter`

## Requirements
- R1: A valid high excursion (rest, then high, then rest) lowers the trim code by exactly one. The code changes only at the clock edge that first samples rest after the high level.
- R2: A valid low excursion (rest, then low, then rest) raises the trim code by exactly one. The code changes at the clock edge that first samples rest after the low level.
- R3: The trim code clamps at 255 when raised and at 0 when lowered, and it never wraps.
- R4: An excursion with fewer than MIN_CYC consecutive low or high samples is rejected and leaves the code unchanged. MIN_CYC equals CLK_HZ/1e6 × MIN_US. An excursion of exactly MIN_CYC samples is accepted.
- R5: While cnt_en is low, no excursion changes the trim code.
- R6: The first valid excursion seen after cnt_en goes high is discarded.
- R7: The first valid excursion after a one-cycle save_done pulse is discarded.
- R8: After reset the code is 128. A line that stays at rest (code 2'b00) never changes the code.
- R9: The program level (code 2'b11) never counts as a pulse. An excursion that touches the program level, or that swings between low (2'b01) and high (2'b10) without first returning to rest, is discarded. A new excursion must start from rest.
- R10: ld_stb writes ld_val into the code at the next clock edge. It takes priority over a step that is due in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable; steps are applied only while high |
| ctl_lvl | input | 2 | Resolved line level: 00 rest, 01 low, 10 high, 11 program |
| save_done | input | 1 | One-cycle pulse when a store operation has completed |
| ld_stb | input | 1 | Parallel load strobe |
| ld_val | input | 8 | Value written by the load strobe |
| trim_val | output | 8 | Current trim code |

## Verification
All internal state (the excursion tracker, its width counter and the first-pulse arming flag) shows at the ports only through trim_val. The trim code is compared against a behavioural model at every clock.

- A corrupted width counter shows up as a step that appears or goes missing on the return to rest after an excursion near MIN_CYC samples.
- A stale arming flag shows up as a one-count difference on the first excursion after enable or save.
- A tracker that fails to demand a rest sample shows up after the program-level and low-to-high sequences.

Each of these faults appears in the cycle right after the edge that samples rest.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    // Resolved level of the three-level control line
    typedef enum logic [1:0] {
        LVL_MID  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_PROG = 2'b11
    } lvl_e;

    // Excursion tracker states
    typedef enum logic [1:0] {
        QS_HOLD = 2'b00,  // waiting for a rest sample before anything counts
        QS_REST = 2'b01,  // at rest, ready for an excursion
        QS_LOW  = 2'b10,  // inside a low excursion
        QS_HIGH = 2'b11   // inside a high excursion
    } qstate_e;

    // Step request carried between stages
    typedef struct packed {
        logic up;  // raise the trim code
        logic dn;  // lower the trim code
    } step_t;

    // Minimum pulse width in clock cycles, never below one
    function automatic int unsigned cycles_for_us(input int unsigned hz,
                                                  input int unsigned us);
        int unsigned r;
        r = (hz / 1_000_000) * us;
        if (r < 1) r = 1;
        return r;
    endfunction

endpackage

// File: rtl/tlc_excursion_qual.sv
module tlc_excursion_qual
    import tlc_pkg::*;
#(
    parameter int unsigned MIN_CYC = 1000
) (
    input  logic  clk,
    input  logic  rst,
    input  lvl_e  lvl_i,
    output step_t step_o
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] MIN_W = CW'(MIN_CYC);
    localparam logic [CW-1:0] ONE_W = CW'(1);

    qstate_e        st_q, st_n;
    logic [CW-1:0]  run_q, run_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= QS_HOLD;
            run_q <= '0;
        end else begin
            st_q  <= st_n;
            run_q <= run_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        run_n  = run_q;
        step_o = '0;
        unique case (st_q)
            QS_HOLD: begin
                if (lvl_i == LVL_MID) st_n = QS_REST;
            end
            QS_REST: begin
                unique case (lvl_i)
                    LVL_LOW:  begin st_n = QS_LOW;  run_n = ONE_W; end
                    LVL_HIGH: begin st_n = QS_HIGH; run_n = ONE_W; end
                    LVL_PROG: st_n = QS_HOLD;
                    default:  st_n = QS_REST;
                endcase
            end
            QS_LOW: begin
                if (lvl_i == LVL_LOW) begin
                    run_n = (run_q >= MIN_W) ? run_q : run_q + ONE_W;
                end else if (lvl_i == LVL_MID) begin
                    step_o.up = (run_q >= MIN_W);
                    st_n      = QS_REST;
                end else begin
                    st_n = QS_HOLD;
                end
            end
            QS_HIGH: begin
                if (lvl_i == LVL_HIGH) begin
                    run_n = (run_q >= MIN_W) ? run_q : run_q + ONE_W;
                end else if (lvl_i == LVL_MID) begin
                    step_o.dn = (run_q >= MIN_W);
                    st_n      = QS_REST;
                end else begin
                    st_n = QS_HOLD;
                end
            end
            default: st_n = QS_HOLD;
        endcase
    end

    // R1 R2: the tracker never asks for both directions at once
    p_one_dir_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_o.up, step_o.dn}));

    // R9: after a program-level sample, the next cycle cannot produce a step
    p_prog_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (lvl_i == LVL_PROG) |=> !(step_o.up || step_o.dn));

endmodule

// File: rtl/tlc_first_gate.sv
module tlc_first_gate
    import tlc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  logic  save_i,
    input  step_t step_i,
    output step_t step_o
);
    logic armed_q;
    logic open_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (!en_i || save_i) begin
            armed_q <= 1'b0;
        end else if (step_i.up || step_i.dn) begin
            armed_q <= 1'b1;
        end
    end

    assign open_w    = en_i && !save_i && armed_q;
    assign step_o.up = step_i.up && open_w;
    assign step_o.dn = step_i.dn && open_w;

    // R5: with enable low the gate passes no step in the following cycle
    p_gate_closed_r5: assert property (@(posedge clk) disable iff (rst)
        (!en_i) |=> !armed_q || en_i);

    // R7: a save always leaves the gate disarmed
    p_save_disarms_r7: assert property (@(posedge clk) disable iff (rst)
        save_i |=> !armed_q);

endmodule

// File: rtl/tlc_sat_reg.sv
module tlc_sat_reg
    import tlc_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  step_t        step_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] TOP_V = {W{1'b1}};
    localparam logic [W-1:0] RST_W = W'(RST_VAL);
    localparam logic [W-1:0] ONE_V = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= RST_W;
        end else if (ld_i) begin
            q_o <= ld_val_i;
        end else if (step_i.up && q_o != TOP_V) begin
            q_o <= q_o + ONE_V;
        end else if (step_i.dn && q_o != '0) begin
            q_o <= q_o - ONE_V;
        end
    end

    p_down_one_r1: assert property (@(posedge clk) disable iff (rst)
        (step_i.dn && !ld_i && q_o != '0) |=> q_o == $past(q_o) - ONE_V);

    p_up_one_r2: assert property (@(posedge clk) disable iff (rst)
        (step_i.up && !ld_i && q_o != TOP_V) |=> q_o == $past(q_o) + ONE_V);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (step_i.up && !ld_i && q_o == TOP_V) |=> q_o == TOP_V);

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (step_i.dn && !ld_i && q_o == '0) |=> q_o == '0);

    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> q_o == $past(ld_val_i));

endmodule

// File: rtl/tlc_trim_counter.sv
module tlc_trim_counter
    import tlc_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned MIN_US  = 20,
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic [1:0]   ctl_lvl,
    input  logic         save_done,
    input  logic         ld_stb,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] trim_val
);
    localparam int unsigned MIN_CYC = cycles_for_us(CLK_HZ, MIN_US);

    lvl_e  lvl_w;
    step_t raw_step;
    step_t ok_step;

    assign lvl_w = lvl_e'(ctl_lvl);

    tlc_excursion_qual #(
        .MIN_CYC (MIN_CYC)
    ) u_qual (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl_w),
        .step_o (raw_step)
    );

    tlc_first_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .en_i   (cnt_en),
        .save_i (save_done),
        .step_i (raw_step),
        .step_o (ok_step)
    );

    tlc_sat_reg #(
        .W       (W),
        .RST_VAL (RST_VAL)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .step_i   (ok_step),
        .ld_i     (ld_stb),
        .ld_val_i (ld_val),
        .q_o      (trim_val)
    );

    // R5: with enable low and no load, the code holds
    p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !ld_stb) |=> trim_val == $past(trim_val));

    // R8: a line held at rest for two samples produces no change without a load
    p_rest_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_lvl == 2'b00 && $past(ctl_lvl) == 2'b00 && !ld_stb) |=> trim_val == $past(trim_val));

endmodule

// File: tb/tlc_trim_counter_test.sv
module tlc_trim_counter_test;

    localparam int MINC = 20;  // 1 MHz nominal x 20 us keeps the run short

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [1:0] ctl_lvl = 2'b00;
    logic       save_done = 1'b0;
    logic       ld_stb = 1'b0;
    logic [7:0] ld_val = 8'd0;
    logic [7:0] trim_val;

    int total = 0;
    int bad = 0;
    string cur_req = "R8";
    bit started = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    tlc_trim_counter #(
        .CLK_HZ  (1_000_000),
        .MIN_US  (20),
        .W       (8),
        .RST_VAL (128)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .ctl_lvl   (ctl_lvl),
        .save_done (save_done),
        .ld_stb    (ld_stb),
        .ld_val    (ld_val),
        .trim_val  (trim_val)
    );

    // Behavioural reference: samples of the current excursion kept in a queue
    int m_val;
    bit m_armed;
    bit m_clean;
    int exc[$];

    always @(posedge clk) begin
        bit f_up, f_dn;
        f_up = 0;
        f_dn = 0;
        if (rst) begin
            m_val = 128;
            m_armed = 0;
            m_clean = 0;
            exc.delete();
        end else begin
            if (ctl_lvl == 2'b00) begin
                if (m_clean && exc.size() >= MINC) begin
                    if (exc[0] == 1) f_up = 1;
                    else f_dn = 1;
                end
                exc.delete();
                m_clean = 1;
            end else if (ctl_lvl == 2'b11) begin
                m_clean = 0;
                exc.delete();
            end else if (m_clean && (exc.size() == 0 || exc[0] == int'(ctl_lvl))) begin
                exc.push_back(int'(ctl_lvl));
            end else begin
                m_clean = 0;
                exc.delete();
            end
            if (ld_stb) m_val = int'(ld_val);
            else if (cnt_en && !save_done && m_armed) begin
                if (f_up && m_val < 255) m_val++;
                else if (f_dn && m_val > 0) m_val--;
            end
            if (!cnt_en || save_done) m_armed = 0;
            else if (f_up || f_dn) m_armed = 1;
        end
        started = 1;
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (started) begin
            total++;
            if (trim_val !== m_val[7:0]) begin
                bad++;
                $display("FAIL %s model compare: actual=%0d expected=%0d", cur_req, trim_val, m_val);
            end
        end
    end

    task automatic chk(input string req, input int exp);
        total++;
        if (trim_val !== exp[7:0]) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, trim_val, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Excursion of n samples at level lv, return to rest with an optional load
    task automatic pulse(input logic [1:0] lv, input int n, input bit do_ld = 0,
                         input logic [7:0] v = 8'd0);
        repeat (n) begin
            @(negedge clk);
            ctl_lvl = lv;
        end
        @(negedge clk);
        ctl_lvl = 2'b00;
        ld_stb  = do_ld;
        ld_val  = v;
        @(negedge clk);
        ld_stb = 1'b0;
        idle(3);
    endtask

    task automatic load(input logic [7:0] v);
        @(negedge clk);
        ld_stb = 1'b1;
        ld_val = v;
        @(negedge clk);
        ld_stb = 1'b0;
        idle(2);
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        cur_req = "R8"; chk("R8 reset value", 128);
        idle(100);
        chk("R8 rest line holds", 128);

        cnt_en = 1'b1;
        cur_req = "R6"; pulse(2'b01, 25); chk("R6 first after enable dropped", 128);
        cur_req = "R2"; pulse(2'b01, 25); chk("R2 low excursion raises", 129);

        cur_req = "R1";
        repeat (25) begin @(negedge clk); ctl_lvl = 2'b10; end
        @(negedge clk);
        chk("R1 no change while high", 129);
        ctl_lvl = 2'b00;
        @(negedge clk);
        chk("R1 lowered at return to rest", 128);
        idle(3);

        cur_req = "R4"; pulse(2'b01, MINC - 1); chk("R4 short rejected", 128);
        pulse(2'b01, MINC); chk("R4 exact width accepted", 129);

        cur_req = "R9";
        pulse(2'b11, 30); chk("R9 program level ignored", 129);
        repeat (25) begin @(negedge clk); ctl_lvl = 2'b01; end
        repeat (3) begin @(negedge clk); ctl_lvl = 2'b11; end
        pulse(2'b00, 1); chk("R9 program-touched excursion dropped", 129);
        repeat (25) begin @(negedge clk); ctl_lvl = 2'b01; end
        pulse(2'b10, 25); chk("R9 low-to-high swing dropped", 129);
        pulse(2'b01, 25); chk("R9 recovers after rest", 130);

        cur_req = "R5";
        cnt_en = 1'b0;
        pulse(2'b01, 25); pulse(2'b10, 25); chk("R5 disabled holds", 130);
        cnt_en = 1'b1;
        cur_req = "R6"; pulse(2'b01, 25); chk("R6 first after re-enable dropped", 130);
        pulse(2'b01, 25); chk("R6 second counts", 131);

        cur_req = "R7";
        @(negedge clk); save_done = 1'b1;
        @(negedge clk); save_done = 1'b0;
        pulse(2'b01, 25); chk("R7 first after save dropped", 131);
        pulse(2'b01, 25); chk("R7 second counts", 132);

        cur_req = "R10";
        pulse(2'b01, 25, 1'b1, 8'd77); chk("R10 load beats step", 77);
        pulse(2'b01, 25); chk("R10 steps resume after load", 78);

        cur_req = "R3";
        load(8'd254);
        repeat (3) pulse(2'b01, 25);
        chk("R3 clamp at 255", 255);
        load(8'd1);
        repeat (3) pulse(2'b10, 25);
        chk("R3 clamp at 0", 0);

        cur_req = "R8"; idle(50); chk("R8 rest holds at end", 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule